// File: doc/BRIEF.md
# Saturating Arithmetic Unit With Sticky Flag

This block is a 32-bit arithmetic unit for signal-processing style integer work. Each cycle a 4-bit opcode picks one operation on two operands. The choices are a set of add and subtract forms that clamp instead of wrapping, a signed doubling, and a clamp of a value to a programmable bit width. The clamp can work on the full word or on each 16-bit half of it. The operation logic is combinational. Its result is captured in a register on the next rising clock edge.

A single sticky flag records that some earlier operation hit its limit. Any clamp event sets it. The flag then holds until the surrounding logic raises a dedicated clear input. Software-visible status paths and other condition flags belong to the surrounding logic and are not part of this block.

Top module: `sat_alu`

## Requirements
- R1: Opcode 1 is a signed saturating add. When both operands share a sign and the sum's sign differs from operand A, the result is 0x7FFFFFFF for non-negative A and 0x80000000 for negative A, and the flag is set. In all other cases the result is the plain sum.
- R2: Opcode 2 is a signed saturating subtract (A minus B). When the operands differ in sign and the difference's sign differs from A, the result is clamped in the same way as R1 and the flag is set.
- R3: Opcode 3 is an unsigned add that returns 0xFFFFFFFF and sets the flag when the 32-bit sum carries out. Opcode 4 is an unsigned subtract that returns 0 and sets the flag when B exceeds A.
- R4: Opcode 5 doubles A as a signed value. It returns 0x7FFFFFFF when A is at or above 0x40000000, and 0x80000000 when A is at or below 0xC0000000 as signed values. Both of these cases set the flag, including A = 0xC0000000 exactly. Otherwise it returns A shifted left by one.
- R5: Opcode 0 returns the wrapped 32-bit sum A+B. It sets the flag under the signed overflow rule of R1.
- R6: Opcode 6 clamps signed A to the range -2^n to 2^n-1, where n is the 5-bit width input. A clamp sets the flag.
- R7: Opcode 7 clamps signed A to the range 0 to 2^n-1. A negative A gives 0. A clamp sets the flag.
- R8: Opcodes 8 (signed) and 9 (unsigned) apply the clamp of R6 or R7 separately to bits 15:0 and bits 31:16 of A. Each half is sign-extended first, both halves use the same n, and each 16-bit result returns in its own position. A clamp in either half sets the one shared flag.
- R9: The flag stays set until the clear input is high on a clock edge. An operation that does not clamp leaves the flag unchanged. A clamp in the same cycle as a clear leaves the flag set.
- R10: Opcodes 10 to 15 are unused. They produce a result of 0 and leave the flag unchanged.
- R11: Reset (active-low, asynchronous) forces the result and the flag to 0. The result of an operation appears on the output one clock edge after the operation is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation select |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| sat_n_i | input | 5 | Clamp width n for opcodes 6 to 9 |
| q_clr_i | input | 1 | Clears the sticky flag |
| res_o | output | 32 | Registered result |
| q_o | output | 1 | Sticky saturation flag |

## Verification
The flag is sticky, so one clamp would hide every later one. Before each operation the stimulus therefore runs an idle cycle with the clear input high, which makes each flag check belong to one operation only. The hardest case to reach is a clamp in the same cycle as a clear. A directed sequence covers it by setting the flag, then issuing a clamping operation together with the clear, and then issuing a non-clamping operation together with the clear. The doubling boundary at 0xC0000000 is also driven on purpose. There the doubled value can be represented exactly, yet the flag must still rise.

// File: rtl/sat_alu_pkg.sv
`timescale 1ns/1ps
package sat_alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_QADD   = 4'd0,
    OP_SADD   = 4'd1,
    OP_SSUB   = 4'd2,
    OP_UADD   = 4'd3,
    OP_USUB   = 4'd4,
    OP_DBL    = 4'd5,
    OP_SSAT   = 4'd6,
    OP_USAT   = 4'd7,
    OP_SSAT16 = 4'd8,
    OP_USAT16 = 4'd9
  } op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd9;
endpackage

// File: rtl/sat_addsub.sv
`timescale 1ns/1ps
module sat_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] diff_o,
  output logic         s_add_ov_o,
  output logic         s_sub_ov_o,
  output logic         u_carry_o,
  output logic         u_borrow_o
);
  logic [W:0] sum_x;
  logic [W:0] diff_x;

  assign sum_x  = {1'b0, a_i} + {1'b0, b_i};
  assign diff_x = {1'b0, a_i} - {1'b0, b_i};

  assign sum_o      = sum_x[W-1:0];
  assign diff_o     = diff_x[W-1:0];
  assign u_carry_o  = sum_x[W];
  assign u_borrow_o = diff_x[W];

  // sign-based overflow: operand signs vs result sign
  assign s_add_ov_o = (a_i[W-1] == b_i[W-1]) && (sum_x[W-1]  != a_i[W-1]);
  assign s_sub_ov_o = (a_i[W-1] != b_i[W-1]) && (diff_x[W-1] != a_i[W-1]);
endmodule

// File: rtl/sat_dbl.sv
`timescale 1ns/1ps
module sat_dbl #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] res_o,
  output logic         sat_o
);
  logic hi;
  logic lo;

  // hi: a >= 2^(W-2); lo: a <= -2^(W-2), equality included
  assign hi = ~a_i[W-1] & a_i[W-2];
  assign lo =  a_i[W-1] & (~a_i[W-2] | ~(|a_i[W-3:0]));

  always_comb begin
    if (hi)      res_o = {1'b0, {(W-1){1'b1}}};
    else if (lo) res_o = {1'b1, {(W-1){1'b0}}};
    else         res_o = {a_i[W-2:0], 1'b0};
  end

  assign sat_o = hi | lo;
endmodule

// File: rtl/sat_clamp.sv
`timescale 1ns/1ps
module sat_clamp #(
  parameter int unsigned W     = 32,
  parameter int unsigned OUT_W = 32,
  parameter int unsigned N_W   = 5
) (
  input  logic [W-1:0]     val_i,
  input  logic [N_W-1:0]   n_i,
  input  logic             signed_i,
  output logic [OUT_W-1:0] res_o,
  output logic             sat_o
);
  localparam logic [W-1:0]        ONE  = W'(1);
  localparam logic signed [W-1:0] ZERO = '0;
  localparam logic signed [W-1:0] NEG1 = '1;

  logic [W-1:0]        mask;
  logic signed [W-1:0] top;

  assign mask = (ONE << n_i) - ONE;
  assign top  = $signed(val_i) >>> n_i;

  always_comb begin
    res_o = val_i[OUT_W-1:0];
    sat_o = 1'b0;
    if (signed_i) begin
      if (top > ZERO) begin
        res_o = mask[OUT_W-1:0];
        sat_o = 1'b1;
      end else if (top < NEG1) begin
        res_o = ~mask[OUT_W-1:0];
        sat_o = 1'b1;
      end
    end else begin
      if (val_i[W-1]) begin
        res_o = '0;
        sat_o = 1'b1;
      end else if (val_i > mask) begin
        res_o = mask[OUT_W-1:0];
        sat_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_alu.sv
`timescale 1ns/1ps
module sat_alu
  import sat_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 16,
  parameter int unsigned N_W    = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [N_W-1:0]    sat_n_i,
  input  logic              q_clr_i,
  output logic [DATA_W-1:0] res_o,
  output logic              q_o
);
  localparam int unsigned    LANES = DATA_W / LANE_W;
  localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] sum, diff;
  logic              s_add_ov, s_sub_ov, u_carry, u_borrow;
  logic [DATA_W-1:0] s_clamp;
  logic [DATA_W-1:0] dbl_res;
  logic              dbl_sat;
  logic [DATA_W-1:0] word_res;
  logic              word_sat;
  logic [DATA_W-1:0] lane_pack;
  logic [LANES-1:0]  lane_sat;
  logic [DATA_W-1:0] res_d;
  logic              sat_d;
  logic [DATA_W-1:0] res_q;
  logic              q_q;

  sat_addsub #(.W(DATA_W)) u_addsub (
    .a_i       (a_i),
    .b_i       (b_i),
    .sum_o     (sum),
    .diff_o    (diff),
    .s_add_ov_o(s_add_ov),
    .s_sub_ov_o(s_sub_ov),
    .u_carry_o (u_carry),
    .u_borrow_o(u_borrow)
  );

  sat_dbl #(.W(DATA_W)) u_dbl (
    .a_i  (a_i),
    .res_o(dbl_res),
    .sat_o(dbl_sat)
  );

  sat_clamp #(.W(DATA_W), .OUT_W(DATA_W), .N_W(N_W)) u_word (
    .val_i   (a_i),
    .n_i     (sat_n_i),
    .signed_i(op_i == OP_SSAT),
    .res_o   (word_res),
    .sat_o   (word_sat)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DATA_W-1:0] lane_val;
    logic [LANE_W-1:0] lane_res;

    assign lane_val = {{(DATA_W-LANE_W){a_i[l*LANE_W+LANE_W-1]}}, a_i[l*LANE_W +: LANE_W]};

    sat_clamp #(.W(DATA_W), .OUT_W(LANE_W), .N_W(N_W)) u_lane (
      .val_i   (lane_val),
      .n_i     (sat_n_i),
      .signed_i(op_i == OP_SSAT16),
      .res_o   (lane_res),
      .sat_o   (lane_sat[l])
    );

    assign lane_pack[l*LANE_W +: LANE_W] = lane_res;
  end

  // clamp direction follows operand A's sign for both add and subtract
  assign s_clamp = a_i[DATA_W-1] ? S_MIN : S_MAX;

  always_comb begin
    res_d = '0;
    sat_d = 1'b0;
    case (op_i)
      OP_QADD: begin
        res_d = sum;
        sat_d = s_add_ov;
      end
      OP_SADD: begin
        res_d = s_add_ov ? s_clamp : sum;
        sat_d = s_add_ov;
      end
      OP_SSUB: begin
        res_d = s_sub_ov ? s_clamp : diff;
        sat_d = s_sub_ov;
      end
      OP_UADD: begin
        res_d = u_carry ? '1 : sum;
        sat_d = u_carry;
      end
      OP_USUB: begin
        res_d = u_borrow ? '0 : diff;
        sat_d = u_borrow;
      end
      OP_DBL: begin
        res_d = dbl_res;
        sat_d = dbl_sat;
      end
      OP_SSAT, OP_USAT: begin
        res_d = word_res;
        sat_d = word_sat;
      end
      OP_SSAT16, OP_USAT16: begin
        res_d = lane_pack;
        sat_d = |lane_sat;
      end
      default: begin
        res_d = '0;
        sat_d = 1'b0;
      end
    endcase
  end

  // a new event outranks a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      q_q   <= 1'b0;
    end else begin
      res_q <= res_d;
      q_q   <= (q_q & ~q_clr_i) | sat_d;
    end
  end

  assign res_o = res_q;
  assign q_o   = q_q;
endmodule

// File: rtl/sat_alu_chk.sv
`timescale 1ns/1ps
module sat_alu_chk
  import sat_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              q_clr_i,
  input logic [DATA_W-1:0] res_o,
  input logic              q_o
);
  logic [DATA_W:0]   wide_sum;
  logic [DATA_W-1:0] wrap_sum;
  logic              unused_op;

  assign wide_sum  = {1'b0, a_i} + {1'b0, b_i};
  assign wrap_sum  = wide_sum[DATA_W-1:0];
  assign unused_op = op_i > OP_LAST;

  // R9
  q_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !q_clr_i) |=> q_o);

  // R9
  q_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_clr_i && unused_op) |=> !q_o);

  // R10
  unused_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unused_op |=> (res_o == '0));

  // R10
  unused_q_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unused_op && !q_clr_i) |=> $stable(q_o));

  // R3
  uadd_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_UADD && wide_sum[DATA_W]) |=> (res_o == '1 && q_o));

  // R3
  usub_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_USUB && b_i > a_i) |=> (res_o == '0 && q_o));

  // R5
  qadd_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_QADD) |=> (res_o == $past(wrap_sum)));
endmodule

bind sat_alu sat_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .op_i   (op_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .q_clr_i(q_clr_i),
  .res_o  (res_o),
  .q_o    (q_o)
);

// File: tb/sim_sat_alu.sv
`timescale 1ns/1ps
module sim_sat_alu;
  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -64'sd2147483648;
  localparam longint UMAX = 64'sd4294967295;
  localparam logic [3:0] IDLE = 4'd15;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op = IDLE;
  logic [31:0] a = '0, b = '0;
  logic [4:0]  n = '0;
  logic        clr = 1'b0;
  logic [31:0] res;
  logic        q;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sat_alu u0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .a_i    (a),
    .b_i    (b),
    .sat_n_i(n),
    .q_clr_i(clr),
    .res_o  (res),
    .q_o    (q)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic exec(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                      input logic [4:0] s, input logic c);
    @(negedge clk_i);
    op = o; a = x; b = y; n = s; clr = c;
    @(negedge clk_i);
    op = IDLE; clr = 1'b0;
  endtask

  function automatic longint rng(input longint v, input longint lo, input longint hi,
                                 output bit st);
    st = 1'b0;
    if (v > hi) begin st = 1'b1; return hi; end
    if (v < lo) begin st = 1'b1; return lo; end
    return v;
  endfunction

  function automatic longint sclamp(input longint v, input int s, input bit sgn, output bit st);
    longint hi;
    hi = (64'sd1 <<< s) - 1;
    if (sgn) return rng(v, -(64'sd1 <<< s), hi, st);
    return rng(v, 0, hi, st);
  endfunction

  function automatic void model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                                input logic [4:0] s, output logic [31:0] r, output bit st);
    longint sa, sb, ua, ub, t;
    bit s0, s1;
    sa = longint'($signed(x)); sb = longint'($signed(y));
    ua = {32'd0, x};           ub = {32'd0, y};
    st = 1'b0; r = '0;
    case (o)
      4'd0: begin r = x + y; void'(rng(sa + sb, SMIN, SMAX, st)); end
      4'd1: r = 32'(rng(sa + sb, SMIN, SMAX, st));
      4'd2: r = 32'(rng(sa - sb, SMIN, SMAX, st));
      4'd3: r = 32'(rng(ua + ub, 0, UMAX, st));
      4'd4: r = 32'(rng(ua - ub, 0, UMAX, st));
      4'd5: begin
        t = 2 * sa;
        if (t <= SMIN) begin r = 32'h8000_0000; st = 1'b1; end
        else r = 32'(rng(t, SMIN, SMAX, st));
      end
      4'd6, 4'd7: r = 32'(sclamp(sa, int'(s), o == 4'd6, st));
      4'd8, 4'd9: begin
        r[15:0]  = 16'(sclamp(longint'($signed(x[15:0])),  int'(s), o == 4'd8, s0));
        r[31:16] = 16'(sclamp(longint'($signed(x[31:16])), int'(s), o == 4'd8, s1));
        st = s0 | s1;
      end
      default: begin r = '0; st = 1'b0; end
    endcase
  endfunction

  // isolated run: clear flag, then one operation, check result and flag
  task automatic run(input string tag, input logic [3:0] o, input logic [31:0] x,
                     input logic [31:0] y, input logic [4:0] s);
    logic [31:0] er;
    bit es;
    exec(IDLE, '0, '0, '0, 1'b1);
    exec(o, x, y, s, 1'b0);
    model(o, x, y, s, er, es);
    chk({tag, " result"}, res, er);
    chk({tag, " flag"}, {31'd0, q}, {31'd0, es});
  endtask

  task automatic t_reset;
    chk("R11 reset result", res, '0);
    chk("R11 reset flag", {31'd0, q}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    op = 4'd1; a = 32'd2; b = 32'd3;
    #1 chk("R11 latency before edge", res, '0);
    @(negedge clk_i); op = IDLE;
    chk("R11 latency after edge", res, 32'd5);
    exec(4'd1, 32'h7FFF_FFFF, 32'd1, '0, 1'b0);
    @(negedge clk_i); rst_ni = 1'b0;
    #1 chk("R11 async reset result", res, '0);
    chk("R11 async reset flag", {31'd0, q}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_sadd;
    run("R1 pos ovf", 4'd1, 32'h7FFF_FFFF, 32'd1, '0);
    run("R1 neg ovf", 4'd1, 32'h8000_0000, 32'hFFFF_FFFF, '0);
    run("R1 mixed", 4'd1, 32'h8000_0000, 32'h7FFF_FFFF, '0);
    run("R1 plain", 4'd1, 32'd100, 32'hFFFF_FFF6, '0);
  endtask

  task automatic t_ssub;
    run("R2 pos ovf", 4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, '0);
    run("R2 neg ovf", 4'd2, 32'h8000_0000, 32'd1, '0);
    run("R2 same sign", 4'd2, 32'h8000_0000, 32'h8000_0000, '0);
    run("R2 plain", 4'd2, 32'd5, 32'd9, '0);
  endtask

  task automatic t_unsigned;
    run("R3 add wrap", 4'd3, 32'hFFFF_FFF0, 32'h20, '0);
    run("R3 add exact", 4'd3, 32'hFFFF_FFF0, 32'h0F, '0);
    run("R3 sub wrap", 4'd4, 32'd3, 32'd4, '0);
    run("R3 sub equal", 4'd4, 32'd7, 32'd7, '0);
  endtask

  task automatic t_double;
    run("R4 hi edge", 4'd5, 32'h4000_0000, '0, '0);
    run("R4 below hi", 4'd5, 32'h3FFF_FFFF, '0, '0);
    run("R4 lo edge", 4'd5, 32'hC000_0000, '0, '0);
    run("R4 above lo", 4'd5, 32'hC000_0001, '0, '0);
    run("R4 min", 4'd5, 32'h8000_0000, '0, '0);
  endtask

  task automatic t_qadd;
    run("R5 wrap ovf", 4'd0, 32'h7FFF_FFFF, 32'd1, '0);
    run("R5 no ovf", 4'd0, 32'hFFFF_FFFF, 32'd1, '0);
  endtask

  task automatic t_ssat;
    run("R6 above", 4'd6, 32'd200, '0, 5'd7);
    run("R6 top", 4'd6, 32'd127, '0, 5'd7);
    run("R6 bottom", 4'd6, 32'hFFFF_FF80, '0, 5'd7);
    run("R6 below", 4'd6, 32'hFFFF_FF7F, '0, 5'd7);
    run("R6 n0", 4'd6, 32'd1, '0, 5'd0);
    run("R6 n31", 4'd6, 32'h8000_0000, '0, 5'd31);
  endtask

  task automatic t_usat;
    run("R7 negative", 4'd7, 32'hFFFF_FFFE, '0, 5'd8);
    run("R7 above", 4'd7, 32'd256, '0, 5'd8);
    run("R7 top", 4'd7, 32'd255, '0, 5'd8);
    run("R7 n31", 4'd7, 32'h7FFF_FFFF, '0, 5'd31);
  endtask

  task automatic t_dual;
    run("R8 signed both", 4'd8, 32'h0100_FE00, '0, 5'd7);
    run("R8 signed hi only", 4'd8, 32'h8000_0005, '0, 5'd7);
    run("R8 signed none", 4'd8, 32'hFFC0_003F, '0, 5'd7);
    run("R8 unsigned mix", 4'd9, 32'hFFFF_0123, '0, 5'd8);
    run("R8 unsigned lo only", 4'd9, 32'h0010_8000, '0, 5'd8);
  endtask

  task automatic t_sticky;
    exec(IDLE, '0, '0, '0, 1'b1);
    exec(4'd1, 32'd1, 32'd1, '0, 1'b0);
    chk("R9 no event stays low", {31'd0, q}, 32'd0);
    exec(4'd1, 32'h7FFF_FFFF, 32'd1, '0, 1'b0);
    chk("R9 event sets", {31'd0, q}, 32'd1);
    exec(4'd1, 32'd1, 32'd1, '0, 1'b0);
    chk("R9 holds after clean op", {31'd0, q}, 32'd1);
    chk("R9 clean op result", res, 32'd2);
    exec(IDLE, '0, '0, '0, 1'b1);
    chk("R9 cleared", {31'd0, q}, 32'd0);
    exec(4'd1, 32'd1, 32'd1, '0, 1'b0);
    exec(4'd3, 32'hFFFF_FFFF, 32'd1, '0, 1'b1);
    chk("R9 event with clear sets", {31'd0, q}, 32'd1);
    exec(4'd3, 32'd1, 32'd1, '0, 1'b1);
    chk("R9 clear with clean op", {31'd0, q}, 32'd0);
  endtask

  task automatic t_unused;
    exec(4'd1, 32'h7FFF_FFFF, 32'd1, '0, 1'b0);
    exec(4'd12, 32'h7FFF_FFFF, 32'd1, 5'd3, 1'b0);
    chk("R10 result zero", res, '0);
    chk("R10 flag kept set", {31'd0, q}, 32'd1);
    exec(IDLE, '0, '0, '0, 1'b1);
    exec(4'd10, 32'h8000_0000, 32'd1, 5'd1, 1'b0);
    chk("R10 result zero op10", res, '0);
    chk("R10 flag kept clear", {31'd0, q}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_sadd();
    t_ssub();
    t_unsigned();
    t_double();
    t_qadd();
    t_ssat();
    t_usat();
    t_dual();
    t_sticky();
    t_unused();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule